// File: doc/BRIEF.md
# Packed 16-bit Lane Integer ALU

This block is a vector integer unit. It works on two operand vectors, each packed with `LANES` lanes of 16 bits. One opcode, presented with a valid strobe, selects one of fourteen integer operations, and that operation is applied to every lane in the same cycle. The per-lane results are captured in an output register and returned one clock later with their own valid strobe.

Lane k sits in bits `[16*k+15 : 16*k]` of each vector. Every lane is evaluated by its own copy of the lane datapath, so no carry, borrow or comparison result passes from one lane to the next. All edge behaviour is fixed:

- The wrapping forms keep the low 16 bits.
- The saturating forms clamp to 0x7fff or 0x8000.
- Negating 0x8000 gives 0x8000 again.
- The absolute differences wrap and do not clamp.

The block is meant to sit behind an issue stage that already holds a decoded opcode.

Top module: `lane_alu16_vec`

## Requirements
- R1: Each lane's result depends only on that lane's operands. A lane whose sum or difference wraps or saturates leaves its neighbours unchanged.
- R2: Opcode 0 (add) gives (a+b) mod 2^16 and opcode 2 (sub) gives (a-b) mod 2^16, for example 0x7fff+0x0001=0x8000 and 0x0000-0x8000=0x8000.
- R3: Opcode 1 (adds) and opcode 3 (subs) treat the operands as signed. A result above 32767 becomes 0x7fff and a result below -32768 becomes 0x8000, so adds(0x7fff,0x0001)=0x7fff and adds(0x8000,0xffff)=0x8000.
- R4: Opcode 4 (min) and opcode 5 (max) compare the lanes as signed values, so min(0x8000,0x7fff)=0x8000.
- R5: Opcode 6 (minu) and opcode 7 (maxu) compare the lanes as unsigned values, so minu(0x8000,0x7fff)=0x7fff.
- R6: Opcode 10 (abs) gives |a| and opcode 11 (neg) gives -a, both modulo 2^16, so both map 0x8000 to 0x8000. Operand b has no effect on either opcode.
- R7: Opcode 12 (abssub) gives |a-b| on signed values and opcode 13 (abssubu) gives |a-b| on unsigned values. Both keep the low 16 bits with no clamp, so abssub(0x8000,0x7fff)=0xffff.
- R8: Opcode 8 (avg) gives floor((a+b)/2) and opcode 9 (avgr) gives floor((a+b+1)/2), with a and b taken as signed and no overflow.
- R9: Opcodes 14 and 15 give zero in every lane.
- R10: out_valid is in_valid delayed by one clock. The result of an accepted operation appears on out_result in the same cycle that out_valid is high.
- R11: While in_valid is low, out_result keeps its previous value, whatever the opcode and operand inputs do.
- R12: During reset and after it, out_valid is 0 and out_result is all zeros until the first operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 4 | Opcode (encoding in R2 to R9) |
| in_a | input | 16*LANES | Packed operand vector a |
| in_b | input | 16*LANES | Packed operand vector b (unused by the unary opcodes) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 16*LANES | Registered packed result vector |

## Verification
The hardest situations to reach are lanes that sit exactly on an arithmetic boundary while their neighbours do not. Examples are a 17-bit overflow in one lane beside an in-range lane, or 0x8000 beside 0x7fff where signed and unsigned ordering disagree. Random words almost never produce these cases. The stimulus therefore builds vectors by rotating a small set of boundary words across the lanes with varying offsets between a and b, so every opcode meets every boundary pairing in neighbouring lanes. Seeded random vectors then cover the interior values, and directed replicated vectors pin the single-value cases.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  localparam int LANE_W = 16;

  typedef enum logic [3:0] {
    OP_ADD     = 4'd0,
    OP_ADDS    = 4'd1,
    OP_SUB     = 4'd2,
    OP_SUBS    = 4'd3,
    OP_MIN     = 4'd4,
    OP_MAX     = 4'd5,
    OP_MINU    = 4'd6,
    OP_MAXU    = 4'd7,
    OP_AVG     = 4'd8,
    OP_AVGR    = 4'd9,
    OP_ABS     = 4'd10,
    OP_NEG     = 4'd11,
    OP_ABSDIF  = 4'd12,
    OP_ABSDIFU = 4'd13,
    OP_RSV14   = 4'd14,
    OP_RSV15   = 4'd15
  } lane_op_e;

endpackage

// File: rtl/lane_order_pick.sv
// Shared comparator: selects the smaller or larger of two lane words,
// with either signed or unsigned ordering.
module lane_order_pick
  import lane_alu_pkg::*;
(
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              signed_cmp,
  input  logic              pick_max,
  output logic [LANE_W-1:0] res
);

  logic [LANE_W-1:0] key_a;
  logic [LANE_W-1:0] key_b;
  logic              a_below;

  always_comb begin
    // Flipping the top bit maps signed order onto unsigned order.
    key_a = signed_cmp ? {~a[LANE_W-1], a[LANE_W-2:0]} : a;
    key_b = signed_cmp ? {~b[LANE_W-1], b[LANE_W-2:0]} : b;
    a_below = (key_a < key_b);
    if (pick_max) res = a_below ? b : a;
    else          res = a_below ? a : b;
  end

  // R4 R5
  always_comb begin
    if (!$isunknown({a, b, signed_cmp, pick_max})) begin
      pick_operand_chk: assert ((res == a) || (res == b));
    end
  end

endmodule

// File: rtl/lane_alu16_core.sv
// One 16-bit lane: purely combinational evaluation of all opcodes.
module lane_alu16_core
  import lane_alu_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] res
);

  localparam logic [LANE_W-1:0] SAT_POS = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SAT_NEG = {1'b1, {(LANE_W-1){1'b0}}};

  lane_op_e          op_e;
  logic [LANE_W:0]   s_sum;
  logic [LANE_W:0]   s_dif;
  logic [LANE_W:0]   u_dif;
  logic [LANE_W-1:0] adds_r;
  logic [LANE_W-1:0] subs_r;
  logic [LANE_W-1:0] absd_r;
  logic [LANE_W-1:0] absdu_r;
  logic [LANE_W-1:0] avg_r;
  logic [LANE_W-1:0] avgr_r;
  logic [LANE_W-1:0] abs_r;
  logic [LANE_W-1:0] neg_r;
  logic [LANE_W-1:0] half_a;
  logic [LANE_W-1:0] half_b;
  logic [LANE_W-1:0] ord_r;
  logic              ord_signed;
  logic              ord_max;

  assign op_e = lane_op_e'(op);

  assign ord_signed = (op_e == OP_MIN) || (op_e == OP_MAX);
  assign ord_max    = (op_e == OP_MAX) || (op_e == OP_MAXU);

  lane_order_pick u_pick (
    .a          (a),
    .b          (b),
    .signed_cmp (ord_signed),
    .pick_max   (ord_max),
    .res        (ord_r)
  );

  // 17-bit extended arithmetic for the saturating and distance forms
  always_comb begin
    s_sum = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    s_dif = {a[LANE_W-1], a} - {b[LANE_W-1], b};
    u_dif = {1'b0, a} - {1'b0, b};

    // overflow when the two top bits of the 17-bit value disagree
    if (s_sum[LANE_W] != s_sum[LANE_W-1]) adds_r = s_sum[LANE_W] ? SAT_NEG : SAT_POS;
    else                                   adds_r = s_sum[LANE_W-1:0];
    if (s_dif[LANE_W] != s_dif[LANE_W-1]) subs_r = s_dif[LANE_W] ? SAT_NEG : SAT_POS;
    else                                   subs_r = s_dif[LANE_W-1:0];

    // magnitude of a 17-bit difference, truncated to the lane
    absd_r  = s_dif[LANE_W] ? (~s_dif[LANE_W-1:0] + 1'b1) : s_dif[LANE_W-1:0];
    absdu_r = u_dif[LANE_W] ? (~u_dif[LANE_W-1:0] + 1'b1) : u_dif[LANE_W-1:0];

    // halve each operand first, then add back the dropped low bits
    half_a = {a[LANE_W-1], a[LANE_W-1:1]};
    half_b = {b[LANE_W-1], b[LANE_W-1:1]};
    avg_r  = half_a + half_b + {{(LANE_W-1){1'b0}}, a[0] & b[0]};
    avgr_r = half_a + half_b + {{(LANE_W-1){1'b0}}, a[0] | b[0]};

    neg_r = ~a + 1'b1;
    abs_r = a[LANE_W-1] ? neg_r : a;
  end

  always_comb begin
    unique case (op_e)
      OP_ADD:     res = a + b;
      OP_ADDS:    res = adds_r;
      OP_SUB:     res = a - b;
      OP_SUBS:    res = subs_r;
      OP_MIN,
      OP_MAX,
      OP_MINU,
      OP_MAXU:    res = ord_r;
      OP_AVG:     res = avg_r;
      OP_AVGR:    res = avgr_r;
      OP_ABS:     res = abs_r;
      OP_NEG:     res = neg_r;
      OP_ABSDIF:  res = absd_r;
      OP_ABSDIFU: res = absdu_r;
      default:    res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, a, b})) begin
      // R6
      if (op_e == OP_ABS) begin
        abs_sign_chk: assert (!res[LANE_W-1] || (a == SAT_NEG));
      end
      // R3
      if (op_e == OP_ADDS && !a[LANE_W-1] && !b[LANE_W-1]) begin
        adds_pos_clamp_chk: assert (!res[LANE_W-1]);
      end
      // R3
      if (op_e == OP_ADDS && a[LANE_W-1] && b[LANE_W-1]) begin
        adds_neg_clamp_chk: assert (res[LANE_W-1]);
      end
    end
  end

endmodule

// File: rtl/lane_result_reg.sv
// Output stage: valid flag plus result word with an explicit load enable.
module lane_result_reg #(
  parameter int WIDTH = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic             q_valid,
  output logic [WIDTH-1:0] q
);

  logic             valid_nxt;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    valid_nxt = load;
    q_nxt     = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= valid_nxt;
      q       <= q_nxt;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !q_valid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/lane_alu16_vec.sv
module lane_alu16_vec
  import lane_alu_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [3:0]                in_op,
  input  logic [LANES*LANE_W-1:0]   in_a,
  input  logic [LANES*LANE_W-1:0]   in_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   out_result
);

  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] lane_res;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_alu16_core u_core (
      .op  (in_op),
      .a   (in_a[g*LANE_W +: LANE_W]),
      .b   (in_b[g*LANE_W +: LANE_W]),
      .res (lane_res[g*LANE_W +: LANE_W])
    );
  end

  lane_result_reg #(.WIDTH(VEC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d       (lane_res),
    .q_valid (out_valid),
    .q       (out_result)
  );

endmodule

// File: tb/test_lane_alu16_vec.sv
`timescale 1ns/1ps
module test_lane_alu16_vec;

  localparam int N = 32;
  localparam int VW = N * 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    in_op;
  logic [VW-1:0] in_a;
  logic [VW-1:0] in_b;
  logic          out_valid;
  logic [VW-1:0] out_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [15:0] edges [8] = '{16'h0000, 16'h0001, 16'hffff, 16'h7fff,
                             16'h8000, 16'h8001, 16'h7ffe, 16'haaaa};

  always #4 clk = ~clk;

  lane_alu16_vec #(.LANES(N)) i_lane_alu16_vec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired: actual cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int sat16(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [15:0] ref_lane(int op, logic [15:0] a, logic [15:0] b);
    int sa, sb, ua, ub, r;
    sa = int'($signed(a)); sb = int'($signed(b));
    ua = int'(a); ub = int'(b);
    case (op)
      0:  r = ua + ub;
      1:  r = sat16(sa + sb);
      2:  r = ua - ub;
      3:  r = sat16(sa - sb);
      4:  r = (sa <= sb) ? ua : ub;
      5:  r = (sa >= sb) ? ua : ub;
      6:  r = (ua <= ub) ? ua : ub;
      7:  r = (ua >= ub) ? ua : ub;
      8:  r = (sa + sb) >>> 1;
      9:  r = (sa + sb + 1) >>> 1;
      10: r = (sa < 0) ? -sa : sa;
      11: r = -sa;
      12: begin r = sa - sb; if (r < 0) r = -r; end
      13: begin r = ua - ub; if (r < 0) r = -r; end
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic string req_of(int op);
    case (op)
      0, 2:    return "R2";
      1, 3:    return "R3";
      4, 5:    return "R4";
      6, 7:    return "R5";
      8, 9:    return "R8";
      10, 11:  return "R6";
      12, 13:  return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [VW-1:0] rep(logic [15:0] v);
    logic [VW-1:0] x;
    for (int i = 0; i < N; i++) x[i*16 +: 16] = v;
    return x;
  endfunction

  function automatic logic [VW-1:0] edge_vec(int k);
    logic [VW-1:0] x;
    for (int i = 0; i < N; i++) x[i*16 +: 16] = edges[(i + k) % 8];
    return x;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] x;
    for (int i = 0; i < N; i++) x[i*16 +: 16] = 16'($urandom());
    return x;
  endfunction

  task automatic run_op(input int op, input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input string req);
    logic [VW-1:0] exp_v;
    int bad;
    for (int i = 0; i < N; i++) exp_v[i*16 +: 16] = ref_lane(op, a[i*16 +: 16], b[i*16 +: 16]);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    bad = -1;
    for (int i = 0; i < N; i++)
      if (bad < 0 && out_result[i*16 +: 16] !== exp_v[i*16 +: 16]) bad = i;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R10 op %0d out_valid actual %b expected 1", op, out_valid);
    end else if (bad >= 0) begin
      errors++;
      $display("FAIL %s op %0d lane %0d actual %h expected %h", req, op, bad,
               out_result[bad*16 +: 16], exp_v[bad*16 +: 16]);
    end
  endtask

  initial begin
    logic [VW-1:0] held;
    logic [VW-1:0] va;
    void'($urandom(32'h5eed_1616));
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    checks++;
    if (out_valid !== 1'b0 || out_result !== '0) begin
      errors++;
      $display("FAIL R12 actual valid %b result %h expected 0/0", out_valid, out_result);
    end

    // directed single-value cases
    run_op(0, rep(16'h7fff), rep(16'h0001), "R2");
    run_op(0, rep(16'h8000), rep(16'h8000), "R2");
    run_op(2, rep(16'h0000), rep(16'h8000), "R2");
    run_op(1, rep(16'h7fff), rep(16'h0001), "R3");
    run_op(1, rep(16'h8000), rep(16'hffff), "R3");
    run_op(3, rep(16'h8000), rep(16'h0001), "R3");
    run_op(4, rep(16'h8000), rep(16'h7fff), "R4");
    run_op(6, rep(16'h8000), rep(16'h7fff), "R5");
    run_op(10, rep(16'h8000), rep(16'h1234), "R6");
    run_op(11, rep(16'h8000), rep(16'h0000), "R6");
    run_op(12, rep(16'h8000), rep(16'h7fff), "R7");
    run_op(13, rep(16'h0000), rep(16'hffff), "R7");
    run_op(9, rep(16'h7fff), rep(16'h7fff), "R8");
    run_op(8, rep(16'h8000), rep(16'hffff), "R8");

    // R1: alternate wrapping and quiet lanes
    va = '0;
    for (int i = 0; i < N; i++) va[i*16 +: 16] = (i % 2 == 0) ? 16'h0001 : 16'h0000;
    run_op(0, rep(16'hffff), va, "R1");
    run_op(1, rep(16'h7fff), va, "R1");

    // R6: b must not matter for unary opcodes
    va = rnd_vec();
    run_op(10, va, rnd_vec(), "R6");
    run_op(10, va, ~rnd_vec(), "R6");
    run_op(11, va, rnd_vec(), "R6");

    // boundary words rotated across lanes for every opcode
    for (int op = 0; op < 16; op++)
      for (int k = 1; k < 8; k += 2)
        run_op(op, edge_vec(0), edge_vec(k), req_of(op));

    // seeded random vectors
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 15));
      run_op(op, rnd_vec(), rnd_vec(), req_of(op));
    end

    // R11: hold while idle with changing inputs
    run_op(5, rnd_vec(), rnd_vec(), "R4");
    held = out_result;
    for (int n = 0; n < 4; n++) begin
      in_op = 4'(n); in_a = rnd_vec(); in_b = rnd_vec();
      @(negedge clk);
      checks++;
      if (out_result !== held || out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R11 actual %h/%b expected %h/0", out_result, out_valid, held);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule